// File: doc/BRIEF.md
# Coarse-Fine Conversion Capture Channel

This block is the digital half of one channel in a multi-channel ramp digitizer. A shared counter, driven elsewhere, runs from the start of the ramp and is broadcast to every channel in Gray code. When the channel's comparator fires, its asynchronous edge is brought into the clock domain through a two-stage synchronizer. The first synchronized cycle freezes both the coarse count on the bus and the 40-tap thermometer word that a per-channel delay line has been filling since the comparator edge. One clock later the frozen word becomes a fine step count and the frozen count becomes binary. The two then merge into one conversion result, announced by a one-cycle valid strobe.

The fine count measures the time from the comparator edge to the latching clock edge. It is therefore subtracted from the scaled coarse count, and a fixed offset makes up for the taps that the synchronizer latency uses. If the counter reaches its last value before the comparator has fired, the channel reports a saturated all-ones result with an overflow flag. A channel is armed by a one-cycle strobe at ramp start and makes at most one report per arming.

Top module: `cfcap_channel`

## Requirements
- R1: After reset, resultValid and overflow are 0 and result is 0.
- R2: fireAsync passes through two flip-flops. If an armed channel first samples it high at edge E1, the count on the bus just before edge E3 is frozen and resultValid is high for exactly one cycle after edge E4. It is low after E3 and again after E5.
- R3: The count bus carries Gray code. The frozen value is converted to binary C, where bit i is the XOR of all Gray bits from i up to the top bit.
- R4: Bit 0 of the tap word is the earliest tap. The fine count F is the number of consecutive ones starting at bit 0, so F is 0 when bit 0 is 0 and 40 when all bits are 1. Set bits above the first zero (bubbles) are ignored, and the tap word is sampled only at the freeze edge.
- R5: result = C*32 + 8 - F, clamped at 0, with a width of COARSE_W+5 bits (12 by default).
- R6: armIn high at an edge arms the channel. A comparator level that an unarmed channel sees produces no strobe and leaves result unchanged. After a capture or an overflow the channel stays unarmed until the next armIn.
- R7: If an armed channel sees the bus at the final count (binary all ones, Gray code 1 followed by zeros) and does not freeze in that cycle, resultValid is high after the next edge, with result all ones and overflow at 1.
- R8: If the freeze and the final count fall in the same cycle, the capture wins. The normal result for C at its maximum is reported one cycle later, with overflow at 0.
- R9: result and overflow keep their values between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, also the coarse counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | One-cycle strobe at ramp start that arms the channel |
| fireAsync | input | 1 | Asynchronous comparator output |
| grayCount | input | COARSE_W (7) | Shared coarse counter bus, Gray coded |
| tapWord | input | 40 | Thermometer states of the delay-line taps |
| result | output | COARSE_W+5 (12) | Merged conversion result |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| overflow | output | 1 | Set with a saturated result when the counter ran out |

## Verification
The comparator freeze and the counter-end detection can fall in the same clock cycle, and they compete for the single report of an arming. The bench provokes this by raising the comparator two cycles before the count bus reaches its final value, so that the synchronized edge lines up exactly with the end value. It then requires that no strobe appears on the saturation timing, that the strobe arrives one cycle later, and that it carries the merged maximum-count result with overflow clear. Random captures at other start points and directed saturation runs check that each path works on its own.

// File: rtl/cfcap_pkg.sv
package cfcap_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic freeze;    // capture bus count and tap word
    logic post;      // register the merged result
    logic saturate;  // register the all-ones overflow result
  } cfcapCtl_t;
endpackage

// File: rtl/cfcap_gray2bin.sv
module cfcap_gray2bin #(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0] grayIn,
  output logic [WIDTH-1:0] binOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign binOut[i] = ^grayIn[WIDTH-1:i];
  end
endmodule

// File: rtl/cfcap_thermo_enc.sv
module cfcap_thermo_enc #(
  parameter int TAPS  = 40,
  localparam int CNT_W = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0] taps,
  output logic [CNT_W-1:0] fineCnt
);
  logic [TAPS-1:0] zeroVec;

  for (genvar i = 0; i < TAPS; i++) begin : g_zero
    assign zeroVec[i] = ~taps[i];
  end

  // leading ones from tap 0; the first zero ends the run, later bubbles ignored
  always_comb begin
    logic found;
    found   = 1'b0;
    fineCnt = CNT_W'(TAPS);
    for (int i = 0; i < TAPS; i++) begin
      if (!found && zeroVec[i]) begin
        fineCnt = CNT_W'(i);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfcap_ctrl.sv
module cfcap_ctrl
  import cfcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armIn,
  input  logic       fireAsync,
  input  logic       busAtEnd,
  output cfcapCtl_t  ctl,
  output logic       resultValid
);
  logic syncA, syncB, armed, pending, validQ;

  always_comb begin
    ctl.freeze   = armed & syncB & ~armIn;
    ctl.post     = pending;
    ctl.saturate = armed & busAtEnd & ~syncB & ~armIn & ~pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      armed   <= 1'b0;
      pending <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      syncA   <= fireAsync;
      syncB   <= syncA;
      pending <= ctl.freeze;
      validQ  <= ctl.post | ctl.saturate;
      if (armIn)
        armed <= 1'b1;
      else if (ctl.freeze || ctl.saturate)
        armed <= 1'b0;
    end
  end

  assign resultValid = validQ;
endmodule

// File: rtl/cfcap_datapath.sv
module cfcap_datapath
  import cfcap_pkg::*;
#(
  parameter int COARSE_W   = 7,
  parameter int FINE_STEPS = 32,
  parameter int EXTRA_TAPS = 8,
  parameter int TAP_OFFSET = 8,
  localparam int FINE_W    = $clog2(FINE_STEPS),
  localparam int TAPS      = FINE_STEPS + EXTRA_TAPS,
  localparam int RES_W     = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfcapCtl_t           ctl,
  input  logic [COARSE_W-1:0] grayCount,
  input  logic [TAPS-1:0]     tapWord,
  output logic                busAtEnd,
  output logic [RES_W-1:0]    result,
  output logic                overflow
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam int SUM_W = RES_W + 1;

  logic [COARSE_W-1:0] liveBin, frozenGray, frozenBin;
  logic [TAPS-1:0]     frozenTaps;
  logic [CNT_W-1:0]    fineCnt;
  logic [SUM_W-1:0]    scaled, fineExt;
  logic [RES_W-1:0]    merged;

  cfcap_gray2bin #(.WIDTH(COARSE_W)) u_liveConv (
    .grayIn(grayCount), .binOut(liveBin));
  assign busAtEnd = &liveBin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frozenGray <= '0;
      frozenTaps <= '0;
    end else if (ctl.freeze) begin
      frozenGray <= grayCount;
      frozenTaps <= tapWord;
    end
  end

  cfcap_gray2bin #(.WIDTH(COARSE_W)) u_frozenConv (
    .grayIn(frozenGray), .binOut(frozenBin));

  cfcap_thermo_enc #(.TAPS(TAPS)) u_enc (
    .taps(frozenTaps), .fineCnt(fineCnt));

  always_comb begin
    scaled  = SUM_W'({frozenBin, {FINE_W{1'b0}}}) + SUM_W'(TAP_OFFSET);
    fineExt = SUM_W'(fineCnt);
    if (scaled < fineExt)
      merged = '0;
    else
      merged = RES_W'(scaled - fineExt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      overflow <= 1'b0;
    end else if (ctl.post) begin
      result   <= merged;
      overflow <= 1'b0;
    end else if (ctl.saturate) begin
      result   <= '1;
      overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/cfcap_channel.sv
module cfcap_channel
  import cfcap_pkg::*;
#(
  parameter int COARSE_W   = 7,
  parameter int FINE_STEPS = 32,
  parameter int EXTRA_TAPS = 8,
  parameter int TAP_OFFSET = EXTRA_TAPS
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     armIn,
  input  logic                                     fireAsync,
  input  logic [COARSE_W-1:0]                      grayCount,
  input  logic [FINE_STEPS+EXTRA_TAPS-1:0]         tapWord,
  output logic [COARSE_W+$clog2(FINE_STEPS)-1:0]   result,
  output logic                                     resultValid,
  output logic                                     overflow
);
  cfcapCtl_t ctl;
  logic      busAtEnd;

  cfcap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armIn(armIn), .fireAsync(fireAsync),
    .busAtEnd(busAtEnd), .ctl(ctl), .resultValid(resultValid));

  cfcap_datapath #(
    .COARSE_W(COARSE_W), .FINE_STEPS(FINE_STEPS),
    .EXTRA_TAPS(EXTRA_TAPS), .TAP_OFFSET(TAP_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .grayCount(grayCount),
    .tapWord(tapWord), .busAtEnd(busAtEnd), .result(result),
    .overflow(overflow));
endmodule

// File: rtl/cfcap_checker.sv
module cfcap_checker #(
  parameter int COARSE_W = 7,
  parameter int RES_W    = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                fireAsync,
  input logic [COARSE_W-1:0] grayCount,
  input logic [RES_W-1:0]    result,
  input logic                resultValid,
  input logic                overflow
);
  logic grayAtEnd;
  assign grayAtEnd = (grayCount == {1'b1, {(COARSE_W-1){1'b0}}});

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !overflow) |-> $past(fireAsync, 4)); // R2

  AST_OVF_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (&result)); // R7

  AST_OVF_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && overflow) |-> $past(grayAtEnd)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(result) && $stable(overflow))); // R9
endmodule

bind cfcap_channel cfcap_checker #(
  .COARSE_W(COARSE_W), .RES_W(COARSE_W + $clog2(FINE_STEPS))
) u_chk (
  .clk(clk), .rstN(rstN), .fireAsync(fireAsync), .grayCount(grayCount),
  .result(result), .resultValid(resultValid), .overflow(overflow));

// File: tb/cfcap_channel_bench.sv
`timescale 1ns/1ps
module cfcap_channel_bench;
  localparam int CW   = 7;
  localparam int MAXC = (1 << CW) - 1;
  localparam int TAPS = 40;
  localparam int RW   = CW + 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armIn = 1'b0;
  logic fireAsync = 1'b0;
  logic [TAPS-1:0] tapWord = '0;
  logic [CW-1:0] grayCount;
  logic [RW-1:0] result;
  logic resultValid, overflow;
  int cnt = 0;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (armIn) cnt <= 0;
    else if (cnt != MAXC) cnt <= cnt + 1;
  end
  assign grayCount = CW'(cnt) ^ (CW'(cnt) >> 1);

  cfcap_channel u_cfcap_channel (
    .clk(clk), .rstN(rstN), .armIn(armIn), .fireAsync(fireAsync),
    .grayCount(grayCount), .tapWord(tapWord), .result(result),
    .resultValid(resultValid), .overflow(overflow));

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expRes(int c, int f);
    int r = c * 32 + 8 - f;
    return (r < 0) ? 0 : r;
  endfunction

  function automatic logic [TAPS-1:0] mkTaps(int f, bit bub);
    logic [TAPS-1:0] t = '0;
    for (int i = 0; i < f; i++) t[i] = 1'b1;
    if (bub && f + 2 < TAPS) begin
      t[f+1] = 1'b1;
      t[f+2] = 1'b1;
    end
    return t;
  endfunction

  task automatic armPulse();
    @(negedge clk) armIn = 1'b1;
    @(negedge clk) armIn = 1'b0;
  endtask

  // fire raised when the bench count equals startAt; captured count = startAt+2
  task automatic capture(int startAt, int f, bit bub, string tag);
    int c;
    logic [RW-1:0] held;
    armPulse();
    while (cnt != startAt) @(negedge clk);
    fireAsync = 1'b1;
    tapWord = mkTaps(f, bub);
    @(negedge clk);
    @(negedge clk);
    c = cnt;
    @(negedge clk);
    check({tag, " R2 no strobe after freeze edge"}, resultValid, 0);
    tapWord = ~tapWord;  // R4: change after freeze has no effect
    @(negedge clk);
    check({tag, " R2 strobe"}, resultValid, 1);
    check({tag, " R3 R5 value"}, result, expRes(c, f));
    check({tag, " overflow clear"}, overflow, 0);
    held = result;
    fireAsync = 1'b0;
    @(negedge clk);
    check({tag, " R2 single strobe"}, resultValid, 0);
    check({tag, " R9 held"}, result, held);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [RW-1:0] held;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid", resultValid, 0);
    check("R1 overflow", overflow, 0);
    check("R1 result", result, 0);

    // directed fine-code corners
    capture(10, 8, 0, "R5 nominal");
    capture(20, 40, 0, "R4 all taps set");
    capture(30, 0, 0, "R4 no taps set");
    capture(40, 10, 1, "R4 bubble");
    capture(50, 0, 1, "R4 bubble tap0 clear");

    // R6: comparator while unarmed
    held = result;
    fireAsync = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R6 idle fire no strobe", resultValid, 0);
    end
    check("R6 idle fire result kept", result, held);
    fireAsync = 1'b0;
    repeat (3) @(negedge clk);

    // R5 clamp: comparator already high at arm, count 0 captured
    for (int k = 0; k < 2; k++) begin
      int f = (k == 0) ? 20 : 5;
      fireAsync = 1'b1;
      tapWord = mkTaps(f, 0);
      repeat (3) @(negedge clk);
      armPulse();
      @(negedge clk);
      check("R5 early fire no strobe yet", resultValid, 0);
      @(negedge clk);
      check("R5 early fire strobe", resultValid, 1);
      check("R5 clamp value", result, expRes(0, f));
      fireAsync = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R7: counter runs out
    armPulse();
    while (cnt != MAXC) @(negedge clk);
    check("R7 no strobe before end edge", resultValid, 0);
    @(negedge clk);
    check("R7 strobe", resultValid, 1);
    check("R7 all ones", result, (1 << RW) - 1);
    check("R7 overflow", overflow, 1);
    @(negedge clk);
    check("R9 overflow held", overflow, 1);
    check("R6 no second report", resultValid, 0);
    repeat (3) @(negedge clk);

    // R8: freeze coincides with final count
    capture(MAXC - 2, 17, 0, "R8 coincidence");

    // random captures
    for (int t = 0; t < 40; t++) begin
      int s = $urandom % 120;
      int f = $urandom % 41;
      bit b = 1'($urandom % 2);
      capture(s, f, b, "R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule